// File: doc/BRIEF.md
# Byte-Lane Load/Store Alignment Unit

This block connects a 32-bit processor datapath to a data memory that is one word wide. The effective byte address is formed from a base register and a signed 16-bit displacement. On a store it produces the word index, a four-bit lane-enable mask and the write word with the data placed on the correct lanes. On a load it takes the word the memory returned and picks out the addressed byte, sign-extended, or passes the whole word through.

Lanes are big-endian: byte offset 0 is the most significant byte of the word. A word access whose address is not a multiple of four is reported on an error output, and no lane is enabled for it. The load path registers the byte offset and the access size at the request, so it lines up with a memory that answers one cycle later. The store path and the address path are combinational.

Top module: `lsu_lane_align`

## Requirements
- R1: The effective address is base + sign-extended 16-bit displacement, modulo 2^32, and it appears on `eff_addr`.
- R2: `word_addr` equals the effective address bits [31:2].
- R3: For an aligned word store (size=1), `lane_en` is 4'b1111 and `wr_data` equals the store data.
- R4: For a byte store (size=0), the low byte of the store data is copied onto all four lanes of `wr_data`, and `lane_en` has exactly one bit set: offset k sets bit (3-k). Bit 3 is lanes [31:24].
- R5: For a word access with address bits [1:0] not equal to zero, `misalign` is 1 and `lane_en` is 0. A byte access never sets `misalign`.
- R6: When `req` is 0, `lane_en` is 0 and `misalign` is 0.
- R7: A byte load returns, one cycle after the request, the byte at offset k of the memory word, taken from bits [31-8k -: 8] and sign-extended to 32 bits.
- R8: A word load returns the memory word unchanged one cycle after the request.
- R9: After reset, `ld_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request valid |
| is_store | input | 1 | 1 = store, 0 = load |
| size_word | input | 1 | 1 = word, 0 = byte |
| base | input | 32 | Base register value |
| disp | input | 16 | Signed displacement |
| st_data | input | 32 | Register data to store |
| mem_rdata | input | 32 | Word returned by memory, one cycle after a request |
| eff_addr | output | 32 | Effective byte address |
| word_addr | output | 30 | Word index to memory |
| lane_en | output | 4 | Byte-lane write enables |
| wr_data | output | 32 | Lane-placed write data |
| misalign | output | 1 | Misaligned word access |
| ld_data | output | 32 | Extracted load result |

## Verification
The address adder is tried with positive, negative and wrapping displacements. This separates sign extension from zero extension of the displacement. Byte stores are swept over all four offsets with distinct data bytes, which exposes swapped lanes and a little-endian mask. Word accesses are swept over all four offsets, which separates the aligned case from each misaligned one. Byte loads use a memory word whose four bytes are all different and have both signs, so a wrong lane choice or missing sign extension gives a different value.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int XLEN   = 32;
  localparam int LANES  = XLEN / 8;
  localparam int OFFW   = $clog2(LANES);
  localparam int DISPW  = 16;

  typedef logic [OFFW-1:0] off_t;

  function automatic logic [XLEN-1:0] ea_calc(input logic [XLEN-1:0] b,
                                               input logic [DISPW-1:0] d);
    return b + {{(XLEN-DISPW){d[DISPW-1]}}, d};
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input off_t o);
    logic [LANES-1:0] m;
    m = '0;
    m[LANES-1-int'(o)] = 1'b1;
    return m;
  endfunction

  function automatic logic [7:0] pick_byte(input logic [XLEN-1:0] w, input off_t o);
    return w[XLEN-1-8*int'(o) -: 8];
  endfunction
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
(
  input  logic [XLEN-1:0]  base,
  input  logic [DISPW-1:0] disp,
  output logic [XLEN-1:0]  ea,
  output logic [XLEN-OFFW-1:0] widx,
  output off_t             boff
);
  always_comb begin
    ea   = ea_calc(base, disp);
    widx = ea[XLEN-1:OFFW];
    boff = ea[OFFW-1:0];
  end
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
  import lsu_pkg::*;
(
  input  logic             req,
  input  logic             is_store,
  input  logic             size_word,
  input  off_t             boff,
  input  logic [XLEN-1:0]  st_data,
  output logic [LANES-1:0] lane_en,
  output logic [XLEN-1:0]  wr_data,
  output logic             misalign
);
  logic bad_word;
  assign bad_word = size_word && (boff != '0);

  always_comb begin
    misalign = req && bad_word;
    lane_en  = '0;
    if (req && is_store && !bad_word)
      lane_en = size_word ? '1 : lane_mask(boff);
    if (size_word) wr_data = st_data;
    else           wr_data = {LANES{st_data[7:0]}};
  end

  always_comb begin
    assert_lane_onehot_R4: assert (!(req && is_store && !size_word) || $onehot(lane_en));
    assert_no_lanes_misaligned_R5: assert (!misalign || lane_en == '0);
    assert_idle_quiet_R6: assert (req || (lane_en == '0 && !misalign));
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic            size_word,
  input  off_t            boff,
  input  logic [XLEN-1:0] mem_rdata,
  output logic [XLEN-1:0] ld_data
);
  logic  q_valid, q_word;
  off_t  q_off;
  logic [7:0] sel_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_word  <= 1'b0;
      q_off   <= '0;
    end else begin
      q_valid <= take;
      if (take) begin
        q_word <= size_word;
        q_off  <= boff;
      end
    end
  end

  assign sel_byte = pick_byte(mem_rdata, q_off);

  always_comb begin
    if (!q_valid)    ld_data = '0;
    else if (q_word) ld_data = mem_rdata;
    else             ld_data = {{(XLEN-8){sel_byte[7]}}, sel_byte};
  end

  assert_byte_sext_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_word) |-> (ld_data[XLEN-1:8] == '0 || ld_data[XLEN-1:8] == '1));
  assert_word_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && q_word) |-> ld_data == mem_rdata);
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic        is_store,
  input  logic        size_word,
  input  logic [31:0] base,
  input  logic [15:0] disp,
  input  logic [31:0] st_data,
  input  logic [31:0] mem_rdata,
  output logic [31:0] eff_addr,
  output logic [29:0] word_addr,
  output logic [3:0]  lane_en,
  output logic [31:0] wr_data,
  output logic        misalign,
  output logic [31:0] ld_data
);
  off_t boff;
  logic load_take;

  lsu_addr_gen u_addr (
    .base(base), .disp(disp), .ea(eff_addr), .widx(word_addr), .boff(boff)
  );

  lsu_store_lanes u_st (
    .req(req), .is_store(is_store), .size_word(size_word), .boff(boff),
    .st_data(st_data), .lane_en(lane_en), .wr_data(wr_data), .misalign(misalign)
  );

  assign load_take = req && !is_store && !misalign;

  lsu_load_extract u_ld (
    .clk(clk), .rst_n(rst_n), .take(load_take), .size_word(size_word),
    .boff(boff), .mem_rdata(mem_rdata), .ld_data(ld_data)
  );

  assert_word_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && is_store && size_word && eff_addr[1:0] == 2'b00) |-> lane_en == 4'b1111);
  assert_misalign_word_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (req && size_word));
  assert_reset_clear_R9: assert property (@(posedge clk)
    !rst_n |=> ld_data == 32'h0);
endmodule

// File: tb/lsu_lane_align_tb.sv
module lsu_lane_align_tb;
  logic clk = 0, rst_n = 0;
  logic req = 0, is_store = 0, size_word = 0;
  logic [31:0] base = 0, st_data = 0, mem_rdata = 0;
  logic [15:0] disp = 0;
  logic [31:0] eff_addr, wr_data, ld_data;
  logic [29:0] word_addr;
  logic [3:0]  lane_en;
  logic        misalign;
  int checks = 0, fails = 0;
  logic [31:0] mem [0:15];

  always #2.5 clk = ~clk;

  lsu_lane_align u_dut (.*);

  // memory answers one cycle after request
  always_ff @(posedge clk) mem_rdata <= mem[word_addr[3:0]];

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = {8'h81 + 8'(i), 8'h12, 8'hF3, 8'h44} ^ {28'h0, 4'(i)};
    repeat (2) @(posedge clk);
    #1;
    chk("R9", ld_data, 0);
    @(negedge clk); rst_n = 1;

    // R1/R2 address formation
    base = 32'h0000_1000; disp = 16'hFFFC; #1;
    chk("R1", eff_addr, 32'h0000_0FFC); chk("R2", {2'b0, word_addr}, 32'h0000_03FF);
    base = 32'h0000_1000; disp = 16'h7FFF; #1;
    chk("R1", eff_addr, 32'h0000_8FFF);
    base = 32'hFFFF_FFFE; disp = 16'h0004; #1;
    chk("R1", eff_addr, 32'h0000_0002); chk("R2", {2'b0, word_addr}, 0);

    // R6 idle
    req = 0; size_word = 1; is_store = 1; base = 1; disp = 0; #1;
    chk("R6", {27'b0, lane_en, misalign}, 0);

    // store sweeps
    st_data = 32'hA1B2_C3D4;
    for (int o = 0; o < 4; o++) begin
      req = 1; is_store = 1; base = 32'h40 + o; disp = 0;
      size_word = 0; #1;
      chk("R4", {28'b0, lane_en}, 32'(4'b1000 >> o));
      chk("R4", wr_data, 32'hD4D4_D4D4);
      chk("R5", {31'b0, misalign}, 0);
      size_word = 1; #1;
      if (o == 0) begin
        chk("R3", {28'b0, lane_en}, 32'hF); chk("R3", wr_data, st_data);
      end else begin
        chk("R5", {31'b0, misalign}, 1); chk("R5", {28'b0, lane_en}, 0);
      end
    end

    // load sweeps
    for (int w = 0; w < 4; w++)
      for (int o = 0; o < 4; o++) begin
        logic [31:0] word, ex;
        logic [7:0] b;
        @(negedge clk);
        req = 1; is_store = 0; size_word = 0; base = 32'(w*4 + o); disp = 0;
        @(negedge clk);
        req = 0;
        word = mem[w];
        b = word[31 - 8*o -: 8];
        ex = {{24{b[7]}}, b};
        chk("R7", ld_data, ex);
      end
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      req = 1; is_store = 0; size_word = 1; base = 32'(w*4 + 32); disp = 16'hFFE0;
      @(negedge clk);
      req = 0;
      chk("R8", ld_data, mem[w]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule